// File: doc/BRIEF.md
# Dual-Device Serial Flash Read Controller

This block is the master side of a shared SPI bus that carries up to two serial flash devices, each on its own active-low select line. A host issues a read through a valid/ready request port: a 25-bit address, a byte count and a choice between a plain read and a fast read that uses two data lines. Data bytes come back, in address order, on a valid/ready stream. When the stream sink stalls, the controller parks the serial clock low between bytes, so no byte is dropped and no buffer is needed.

Once reset is released and the power-good input is high, the controller reads a 32-bit signature word from the first device by itself. The signature result drives a mode output that selects descriptor or non-descriptor operation. Host requests are held off until that check is done. Until power-good is seen, every bus output stays in high impedance. The serial clock is generated from the system clock through a divider whose value software places on an input while the bus is idle.

Top module: `spi_flash_reader`

## Requirements
- R1: While the power-good input has been low on the previous clock edge, `spi_oe` and `spi_mosi_oe` are 0, so the clock, both selects and MOSI are high-impedance. No bus transaction starts before power-good is seen.
- R2: Whenever both selects are high (1), `spi_sclk` is 0.
- R3: At most one select is low at any time. Address bit 24 = 1 drives select 1 (`spi_cs_n[1]`) low, and bit 24 = 0 drives select 0 (`spi_cs_n[0]`) low.
- R4: A plain read (`req_dual` = 0) shifts out opcode 0x03 and then address bits 23:0, MSB first, with no dummy clocks. MOSI changes only while `spi_sclk` is low, and the next bit is sampled on the rising edge.
- R5: A dual read (`req_dual` = 1) sends opcode 0x3B and the address on MOSI only, then 8 dummy clocks with `spi_mosi_oe` = 0. Each later rising edge then samples two bits: MISO carries the odd bit (7, 5, 3, 1) and the MOSI pin carries the even bit (6, 4, 2, 0), with the most significant pair first. MOSI is never driven while the flash drives it.
- R6: After power-good, the controller reads 4 bytes at offset 0x10 on select 0 using opcode 0x03, first byte most significant. `sig_done` then rises, and `desc_mode` is 1 exactly when the word equals 0x0FF0A55A. `req_ready` stays 0 until `sig_done` is 1.
- R7: Each high phase of `spi_sclk` lasts exactly `clk_div`+1 system clocks. Each low phase within a transfer lasts at least that long.
- R8: After the last rising serial clock edge of a request, the select stays low for at least 2·(`clk_div`+1) system clocks, which is one serial clock period.
- R9: A request delivers exactly `req_len`+1 bytes, from consecutive flash addresses, in order. While `rd_valid`=1 and `rd_ready`=0, `rd_data` holds steady, and stalls lose no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply good; bus outputs enabled once seen high |
| clk_div | input | DIV_W | Serial clock half period minus one, in system clocks; change only when idle |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_addr | input | ADDR_W | Bit 24 selects device, bits 23:0 flash address |
| req_len | input | LEN_W | Number of bytes minus one |
| req_dual | input | 1 | 1 = dual-output fast read, 0 = plain read |
| rd_data | output | 8 | Returned byte |
| rd_valid | output | 1 | rd_data holds a byte |
| rd_ready | input | 1 | Sink accepts the byte |
| sig_done | output | 1 | Signature check finished |
| desc_mode | output | 1 | 1 = descriptor mode, 0 = non-descriptor mode |
| spi_oe | output | 1 | Output enable for clock and selects |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 2 | Active-low device selects |
| spi_mosi | output | 1 | MOSI output value |
| spi_mosi_oe | output | 1 | MOSI output enable |
| spi_miso | input | 1 | MISO data in |
| spi_mosi_in | input | 1 | MOSI pin read back as second data input |

## Verification
Two situations are hardest to reach from the ports.

The first is a stream stall that lands exactly on a byte boundary in the middle of a long read. The bench holds `rd_ready` low for 39 of every 40 cycles during a ten-byte plain read, and cycles it more gently across the main sweep. It then compares every byte against the flash model's computed contents. A lost or doubled byte would show up as a mismatch.

The second is a host request that is already pending before power-good and before the signature check. The bench raises `req_valid` during reset, with power-good low. It then confirms that the first command on the bus is still the signature fetch at 0x10. It also covers the case where the signature does not match.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam logic [7:0] OP_PLAIN = 8'h03;
  localparam logic [7:0] OP_DUAL  = 8'h3B;
  localparam int BYTE_W  = 8;
  localparam int DUMMY_N = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_CMD,
    ST_DUMMY,
    ST_DATA,
    ST_HOLD,
    ST_GAP
  } rd_state_t;
endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q == div) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  assign tick = run && (cnt_q == div);
endmodule

// File: rtl/spi_rd_rx.sv
module spi_rd_rx
  import spi_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              dual,
  input  logic              miso,
  input  logic              mosi_in,
  output logic [BYTE_W-1:0] data
);
  logic [BYTE_W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '0;
    else if (sample) begin
      if (dual) sr_q <= {sr_q[BYTE_W-3:0], miso, mosi_in};
      else      sr_q <= {sr_q[BYTE_W-2:0], miso};
    end
  end

  assign data = sr_q;
endmodule

// File: rtl/spi_rd_stream.sv
module spi_rd_stream
  import spi_rd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] din,
  output logic [BYTE_W-1:0] dout,
  output logic              valid,
  input  logic              ready
);
  logic [BYTE_W-1:0] data_q;
  logic              valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else if (push) begin
      data_q  <= din;
      valid_q <= 1'b1;
    end else if (ready) begin
      valid_q <= 1'b0;
    end
  end

  assign dout  = data_q;
  assign valid = valid_q;
endmodule

// File: rtl/spi_flash_reader.sv
module spi_flash_reader
  import spi_rd_pkg::*;
#(
  parameter int          DIV_W      = 8,
  parameter int          LEN_W      = 8,
  parameter int          ADDR_W     = 25,
  parameter logic [23:0] SIG_OFFSET = 24'h000010,
  parameter logic [31:0] SIG_VALUE  = 32'h0FF0A55A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_good,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_dual,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              sig_done,
  output logic              desc_mode,
  output logic              spi_oe,
  output logic              spi_sclk,
  output logic [1:0]        spi_cs_n,
  output logic              spi_mosi,
  output logic              spi_mosi_oe,
  input  logic              spi_miso,
  input  logic              spi_mosi_in
);
  localparam int FA_W     = ADDR_W - 1;
  localparam int CMD_W    = 8 + FA_W;
  localparam int CNT_BITS = $clog2(CMD_W + 1);
  localparam int PAIRS    = BYTE_W / 2;
  localparam int SIG_B    = 4;

  rd_state_t             state_q;
  logic                  pg_q;
  logic                  sclk_q;
  logic [1:0]            cs_n_q;
  logic                  mosi_q;
  logic                  mosi_rel_q;
  logic [CMD_W-1:0]      tx_q;
  logic [CNT_BITS-1:0]   bit_q;
  logic [LEN_W-1:0]      left_q;
  logic                  last_q;
  logic                  dual_q;
  logic                  sig_phase_q;
  logic                  sig_done_q;
  logic                  desc_q;
  logic [31:0]           sig_word_q;
  logic                  byte_done_q;
  logic                  wait_q;

  logic                  run;
  logic                  tick;
  logic                  can_rise;
  logic                  last_bit;
  logic                  rx_sample;
  logic [BYTE_W-1:0]     rx_byte;
  logic                  in_xfer;

  assign run      = (state_q != ST_IDLE);
  assign in_xfer  = (state_q == ST_CMD) || (state_q == ST_DUMMY) || (state_q == ST_DATA);
  assign last_bit = (bit_q == (dual_q ? CNT_BITS'(PAIRS - 1) : CNT_BITS'(BYTE_W - 1)));
  assign can_rise = !((state_q == ST_DATA) && (bit_q == '0) && !sig_phase_q &&
                      (rd_valid || byte_done_q));
  assign rx_sample = tick && (state_q == ST_DATA) && !sclk_q && can_rise;

  spi_rd_tick #(.DIV_W(DIV_W)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .div  (clk_div),
    .tick (tick)
  );

  spi_rd_rx u_rx (
    .clk     (clk),
    .rst     (rst),
    .sample  (rx_sample),
    .dual    (dual_q),
    .miso    (spi_miso),
    .mosi_in (spi_mosi_in),
    .data    (rx_byte)
  );

  spi_rd_stream u_out (
    .clk   (clk),
    .rst   (rst),
    .push  (byte_done_q && !sig_phase_q),
    .din   (rx_byte),
    .dout  (rd_data),
    .valid (rd_valid),
    .ready (rd_ready)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      pg_q        <= 1'b0;
      sclk_q      <= 1'b0;
      cs_n_q      <= 2'b11;
      mosi_q      <= 1'b0;
      mosi_rel_q  <= 1'b0;
      tx_q        <= '0;
      bit_q       <= '0;
      left_q      <= '0;
      last_q      <= 1'b0;
      dual_q      <= 1'b0;
      sig_phase_q <= 1'b0;
      sig_done_q  <= 1'b0;
      desc_q      <= 1'b0;
      sig_word_q  <= '0;
      byte_done_q <= 1'b0;
      wait_q      <= 1'b0;
    end else begin
      pg_q        <= pwr_good;
      byte_done_q <= 1'b0;
      if (byte_done_q && sig_phase_q)
        sig_word_q <= {sig_word_q[23:0], rx_byte};

      case (state_q)
        ST_IDLE: begin
          sclk_q <= 1'b0;
          bit_q  <= '0;
          last_q <= 1'b0;
          if (pg_q && !sig_done_q) begin
            tx_q        <= {OP_PLAIN, SIG_OFFSET[FA_W-1:0]};
            mosi_q      <= OP_PLAIN[7];
            dual_q      <= 1'b0;
            left_q      <= LEN_W'(SIG_B - 1);
            sig_phase_q <= 1'b1;
            cs_n_q      <= 2'b10;
            state_q     <= ST_SETUP;
          end else if (req_valid && req_ready) begin
            tx_q        <= {(req_dual ? OP_DUAL : OP_PLAIN), req_addr[FA_W-1:0]};
            mosi_q      <= req_dual ? OP_DUAL[7] : OP_PLAIN[7];
            dual_q      <= req_dual;
            left_q      <= req_len;
            cs_n_q      <= req_addr[ADDR_W-1] ? 2'b01 : 2'b10;
            state_q     <= ST_SETUP;
          end
        end

        ST_SETUP: begin
          if (tick) state_q <= ST_CMD;
        end

        ST_CMD, ST_DUMMY, ST_DATA: begin
          if (tick) begin
            if (!sclk_q) begin
              if (can_rise) begin
                sclk_q <= 1'b1;
                if ((state_q == ST_DATA) && last_bit) begin
                  bit_q       <= '0;
                  byte_done_q <= 1'b1;
                  if (left_q == '0) last_q <= 1'b1;
                  else              left_q <= left_q - 1'b1;
                end else begin
                  bit_q <= bit_q + 1'b1;
                end
              end
            end else begin
              sclk_q <= 1'b0;
              if (state_q == ST_CMD) begin
                if (bit_q == CNT_BITS'(CMD_W)) begin
                  bit_q <= '0;
                  if (dual_q) begin
                    state_q    <= ST_DUMMY;
                    mosi_rel_q <= 1'b1;
                  end else begin
                    state_q    <= ST_DATA;
                  end
                end else begin
                  tx_q   <= {tx_q[CMD_W-2:0], 1'b0};
                  mosi_q <= tx_q[CMD_W-2];
                end
              end else if (state_q == ST_DUMMY) begin
                if (bit_q == CNT_BITS'(DUMMY_N)) begin
                  bit_q   <= '0;
                  state_q <= ST_DATA;
                end
              end else if (last_q) begin
                wait_q  <= 1'b0;
                state_q <= ST_HOLD;
              end
            end
          end
        end

        ST_HOLD: begin
          if (tick) begin
            if (wait_q) begin
              wait_q     <= 1'b0;
              cs_n_q     <= 2'b11;
              mosi_rel_q <= 1'b0;
              mosi_q     <= 1'b0;
              state_q    <= ST_GAP;
              if (sig_phase_q) begin
                sig_phase_q <= 1'b0;
                sig_done_q  <= 1'b1;
                desc_q      <= (sig_word_q == SIG_VALUE);
              end
            end else begin
              wait_q <= 1'b1;
            end
          end
        end

        ST_GAP: begin
          if (tick) begin
            if (wait_q) begin
              wait_q  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              wait_q <= 1'b1;
            end
          end
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready   = (state_q == ST_IDLE) && sig_done_q && pg_q && !in_xfer;
  assign sig_done    = sig_done_q;
  assign desc_mode   = desc_q;
  assign spi_oe      = pg_q;
  assign spi_sclk    = sclk_q;
  assign spi_cs_n    = cs_n_q;
  assign spi_mosi    = mosi_q;
  assign spi_mosi_oe = pg_q && !mosi_rel_q;
endmodule

// File: rtl/spi_flash_reader_chk.sv
module spi_flash_reader_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_good,
  input logic       spi_oe,
  input logic       spi_mosi_oe,
  input logic       spi_sclk,
  input logic [1:0] spi_cs_n,
  input logic       spi_mosi,
  input logic       req_ready,
  input logic       sig_done,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data
);
  a_r1_hiz_before_pg: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_good) |-> (!spi_oe && !spi_mosi_oe));

  a_r2_idle_clock_low: assert property (@(posedge clk) disable iff (rst)
    (&spi_cs_n) |-> !spi_sclk);

  a_r3_single_select: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~spi_cs_n));

  a_r4_mosi_steady_high: assert property (@(posedge clk) disable iff (rst)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r5_release_inside_frame: assert property (@(posedge clk) disable iff (rst)
    (spi_oe && !spi_mosi_oe) |-> !(&spi_cs_n));

  a_r6_no_req_before_sig: assert property (@(posedge clk) disable iff (rst)
    !sig_done |-> !req_ready);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

bind spi_flash_reader spi_flash_reader_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .pwr_good    (pwr_good),
  .spi_oe      (spi_oe),
  .spi_mosi_oe (spi_mosi_oe),
  .spi_sclk    (spi_sclk),
  .spi_cs_n    (spi_cs_n),
  .spi_mosi    (spi_mosi),
  .req_ready   (req_ready),
  .sig_done    (sig_done),
  .rd_valid    (rd_valid),
  .rd_ready    (rd_ready),
  .rd_data     (rd_data)
);

// File: tb/sim_spi_flash_reader.sv
module sim_spi_flash_reader;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        pwr_good;
  logic [7:0]  clk_div;
  logic        req_valid;
  logic        req_ready;
  logic [24:0] req_addr;
  logic [7:0]  req_len;
  logic        req_dual;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b1;
  logic        sig_done;
  logic        desc_mode;
  logic        spi_oe;
  logic        spi_sclk;
  logic [1:0]  spi_cs_n;
  logic        spi_mosi;
  logic        spi_mosi_oe;
  logic        miso_d = 1'b1;
  logic        mosi_d = 1'b1;
  logic        mosi_drv = 1'b0;
  logic        mosi_line;

  assign mosi_line = spi_mosi_oe ? spi_mosi : (mosi_drv ? mosi_d : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_flash_reader u0 (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_dual(req_dual),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .sig_done(sig_done), .desc_mode(desc_mode),
    .spi_oe(spi_oe), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe),
    .spi_miso(miso_d), .spi_mosi_in(mosi_line)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic sig_good = 1'b1;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic cs, input logic [23:0] a);
    if (!cs && sig_good && a >= 24'h10 && a <= 24'h13) begin
      case (a[1:0])
        2'd0: return 8'h0F;
        2'd1: return 8'hF0;
        2'd2: return 8'hA5;
        default: return 8'h5A;
      endcase
    end
    return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ (cs ? 8'hC3 : 8'h00);
  endfunction

  // flash model
  logic        prev_sclk = 1'b0;
  int          m_cnt = 0;
  logic [31:0] m_cmd = '0;
  logic [7:0]  obs_op = '0;
  logic [23:0] obs_addr = '0;
  logic        obs_cs = 1'b0;
  int          n_cmds = 0;
  int          contention = 0;

  always @(spi_sclk or spi_cs_n) begin
    if (&spi_cs_n) begin
      m_cnt = 0;
      mosi_drv = 1'b0;
    end else if (spi_sclk && !prev_sclk) begin
      if (m_cnt < 32) m_cmd = {m_cmd[30:0], mosi_line};
      m_cnt++;
      if (m_cnt == 32) begin
        obs_op   = m_cmd[31:24];
        obs_addr = m_cmd[23:0];
        obs_cs   = spi_cs_n[0];
        n_cmds++;
      end
    end else if (!spi_sclk && prev_sclk) begin
      if (obs_op == 8'h03 && m_cnt >= 32) begin
        int k;
        logic [7:0] b;
        k = m_cnt - 32;
        b = mem_byte(obs_cs, obs_addr + 24'(k / 8));
        miso_d = b[7 - (k % 8)];
      end else if (obs_op == 8'h3B && m_cnt >= 40) begin
        int k;
        logic [7:0] b;
        k = m_cnt - 40;
        b = mem_byte(obs_cs, obs_addr + 24'(k / 4));
        miso_d = b[7 - 2 * (k % 4)];
        mosi_d = b[6 - 2 * (k % 4)];
        if (spi_mosi_oe) contention++;
        mosi_drv = 1'b1;
      end
    end
    prev_sclk = spi_sclk;
  end

  // collector and monitors
  logic [7:0] got [0:15];
  int   got_n = 0;
  int   rmode = 0;
  int   cyc = 0;
  int   hi_run = 0;
  int   last_rise = 0;
  logic prev_s = 1'b0;
  logic prev_desel = 1'b1;
  int   viol_r2 = 0, viol_r3 = 0, viol_r6 = 0, viol_r7 = 0, viol_r8 = 0;

  always @(negedge clk) begin
    cyc++;
    case (rmode)
      0: rd_ready = 1'b1;
      1: rd_ready = (cyc % 3) != 0;
      default: rd_ready = (cyc % 40) == 0;
    endcase
    if (rd_valid && rd_ready) begin
      if (got_n < 16) got[got_n] = rd_data;
      got_n++;
    end
    if (!rst) begin
      if ((&spi_cs_n) && spi_sclk) viol_r2++;
      if (!spi_cs_n[0] && !spi_cs_n[1]) viol_r3++;
      if (req_ready && !sig_done) viol_r6++;
      if (spi_sclk) hi_run++;
      else if (prev_s) begin
        if (hi_run != int'(clk_div) + 1) viol_r7++;
        hi_run = 0;
      end
      if (spi_sclk && !prev_s) last_rise = cyc;
      if ((&spi_cs_n) && !prev_desel && (cyc - last_rise) < 2 * (int'(clk_div) + 1))
        viol_r8++;
    end
    prev_s = spi_sclk;
    prev_desel = &spi_cs_n;
  end

  task automatic handshake();
    forever begin
      if (req_ready) begin
        @(negedge clk);
        req_valid = 1'b0;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic finish_req(input logic [24:0] a, input int len_m1, input logic d);
    string tg;
    tg = d ? "R5" : "R4";
    while (got_n < len_m1 + 1) @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(obs_op == (d ? 8'h3B : 8'h03), tg, "opcode", obs_op, d ? 8'h3B : 8'h03);
    chk(obs_addr == a[23:0], tg, "address", obs_addr, a[23:0]);
    chk(obs_cs == a[24], "R3", "select", obs_cs, a[24]);
    chk(got_n == len_m1 + 1, "R9", "byte count", got_n, len_m1 + 1);
    for (int i = 0; i <= len_m1 && i < 16; i++)
      chk(got[i] == mem_byte(a[24], a[23:0] + 24'(i)), d ? "R5" : "R9", "data byte",
          got[i], mem_byte(a[24], a[23:0] + 24'(i)));
  endtask

  task automatic run_req(input logic [24:0] a, input int len_m1, input logic d,
                         input int dv, input int rm);
    @(negedge clk);
    rmode = rm;
    clk_div = 8'(dv);
    got_n = 0;
    req_addr = a;
    req_len = 8'(len_m1);
    req_dual = d;
    req_valid = 1'b1;
    handshake();
    finish_req(a, len_m1, d);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=%0d expected=%0d", WDOG, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; pwr_good = 1'b0; req_valid = 1'b0;
    req_addr = '0; req_len = '0; req_dual = 1'b0; clk_div = 8'd1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state, bus released
    chk(spi_oe == 1'b0, "R1", "spi_oe after reset", spi_oe, 0);
    chk(spi_mosi_oe == 1'b0, "R1", "mosi_oe after reset", spi_mosi_oe, 0);
    chk(rd_valid == 1'b0, "R9", "rd_valid after reset", rd_valid, 0);
    chk(sig_done == 1'b0, "R6", "sig_done after reset", sig_done, 0);
    repeat (60) @(negedge clk);
    chk(spi_oe == 1'b0 && n_cmds == 0, "R1", "activity without power good", n_cmds, 0);
    chk(&spi_cs_n, "R1", "selects idle without power good", spi_cs_n, 3);
    pwr_good = 1'b1;
    while (!sig_done) @(negedge clk);
    chk(desc_mode == 1'b1, "R6", "descriptor mode on match", desc_mode, 1);
    chk(obs_op == 8'h03 && obs_addr == 24'h10, "R6", "signature fetch address", obs_addr, 24'h10);
    chk(obs_cs == 1'b0, "R6", "signature on select 0", obs_cs, 0);
    chk(n_cmds == 1, "R6", "single signature command", n_cmds, 1);

    // sweep: divider, mode, length, device
    for (int dv = 0; dv < 4; dv += (dv == 0) ? 1 : 2) begin
      for (int d = 0; d < 2; d++) begin
        for (int ln = 0; ln < 4; ln++) begin
          logic [24:0] a;
          a = {ln[0] ^ d[0], 24'h000100 + 24'(ln * 37 + dv * 1000 + d * 4099)};
          run_req(a, ln, d[0], dv, (ln + d) % 2);
        end
      end
    end
    // top of device 1, wrapping address, dual
    run_req({1'b1, 24'hFFFFFE}, 3, 1'b1, 0, 0);
    // heavy stall at byte boundaries
    run_req({1'b0, 24'h00ABCD}, 9, 1'b0, 1, 2);
    run_req({1'b1, 24'h123456}, 9, 1'b1, 0, 2);

    // second start: signature mismatch and request pending early
    @(negedge clk);
    rst = 1'b1; pwr_good = 1'b0; sig_good = 1'b0; rmode = 0; got_n = 0;
    req_addr = {1'b1, 24'h000040}; req_len = 8'd2; req_dual = 1'b0; req_valid = 1'b1;
    clk_div = 8'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    chk(req_ready == 1'b0, "R6", "ready before signature", req_ready, 0);
    pwr_good = 1'b1;
    while (!sig_done) @(negedge clk);
    chk(desc_mode == 1'b0, "R6", "non-descriptor on mismatch", desc_mode, 0);
    chk(obs_addr == 24'h10 && obs_cs == 1'b0, "R6", "signature first despite pending request",
        obs_addr, 24'h10);
    handshake();
    finish_req({1'b1, 24'h000040}, 2, 1'b0);

    chk(viol_r2 == 0, "R2", "clock high while idle", viol_r2, 0);
    chk(viol_r3 == 0, "R3", "both selects low", viol_r3, 0);
    chk(viol_r6 == 0, "R6", "ready before signature done", viol_r6, 0);
    chk(viol_r7 == 0, "R7", "clock high width", viol_r7, 0);
    chk(viol_r8 == 0, "R8", "select hold after last clock", viol_r8, 0);
    chk(contention == 0, "R5", "MOSI contention", contention, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule